// File: doc/BRIEF.md
# Patterned Cache Bank Power-Off Selector

This block decides which banks of a two-dimensional grid of last-level cache banks are to be switched off. A sizing engine elsewhere supplies how many banks should go dark. A pattern code picks the geometric rule used to choose them: whole alternate rows, a checkerboard, or closeness to the processing cores. Core closeness comes from a small per-bank distance table that the block holds and that is loaded through a write port.

After a start pulse the block walks the grid over several cycles and builds the power-off mask. It then walks the grid again and gives every dark bank a redirect target, which is the nearest bank still powered. When both walks are finished it raises done and holds the mask, the targets and the overflow flag steady until the next start. Banks are indexed in row-major order: index = row * COLS + column.

Top module: `bank_off_pattern_gen`

## Requirements
- R1: After a synchronous reset, busy, done, overflow and the whole power-off mask are 0.
- R2: With pattern code 0 (row stripes), only banks whose row index is odd can be switched off, and they are taken in ascending bank index until the request is met.
- R3: With pattern code 1 (checkerboard), only banks whose row index plus column index is odd can be switched off, and they are taken in ascending bank index until the request is met.
- R4: With pattern code 2 (core proximity), banks are taken in ascending order of their stored core distance, with the lower bank index first on equal distance. The distances are loaded with dist_we, dist_addr and dist_wdata.
- R5: When done is high, the number of set bits in the mask equals the smaller of the requested count and the number of banks the pattern allows.
- R6: When done is high, overflow is 1 exactly when the requested count exceeded the allowed set. The allowed set is 8 banks for codes 0 and 1 on the default 4x4 grid, all 16 banks for code 2, and no banks for code 3.
- R7: For each dark bank, the IDXW-bit target field at bits [i*IDXW +: IDXW] holds the index of the powered bank with the smallest Manhattan grid distance, with the lower index winning ties. For a powered bank, or when no bank is powered, the field holds the bank's own index.
- R8: A start pulse sets busy on the next cycle and clears done. A start pulse while busy is ignored. While done is high and start is low, the mask, the targets and overflow do not change.
- R9: Pattern code 3 switches no bank off, whatever the requested count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a new mask computation |
| pattern | input | 2 | Pattern code: 0 row stripes, 1 checkerboard, 2 core proximity, 3 none |
| off_count | input | CNTW (5) | Number of banks requested to power off |
| dist_we | input | 1 | Write enable for the core-distance table |
| dist_addr | input | IDXW (4) | Bank index to write |
| dist_wdata | input | DISTW (4) | Core distance of that bank |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Mask, targets and overflow are valid |
| overflow | output | 1 | Request exceeded the banks the pattern allows |
| off_mask | output | N (16) | One bit per bank, 1 = powered off |
| target_flat | output | N*IDXW (64) | Redirect target index per bank |

## Verification
Row stripes are driven with a partial request, an exact-fit request and an over-size request. The partial request shows that the walk stops early and in index order, and the over-size request shows that the count is clamped and flagged. The checkerboard is driven with a count that crosses row boundaries, which separates it from the stripe rule. The proximity pattern is driven with a distance table full of ties, so an ordering by distance alone gives a different mask from one that also uses the index tie-break. An all-banks request leaves no powered bank, which exercises the self-target fallback. Code 3 and a second start sent mid-run show that a request is refused or ignored.

// File: rtl/bopg_pkg.sv
package bopg_pkg;
  typedef enum logic [1:0] {
    PAT_STRIPE = 2'd0,
    PAT_CHECK  = 2'd1,
    PAT_NEAR   = 2'd2,
    PAT_NONE   = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_TGT  = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  // Geometric eligibility for the two walk-order patterns.
  function automatic logic walk_eligible(input logic [1:0] pat, input int idx, input int cols);
    int r;
    int c;
    r = idx / cols;
    c = idx % cols;
    case (pat)
      2'd0:    return r[0];
      2'd1:    return (r[0] ^ c[0]);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bopg_dist_file.sv
module bopg_dist_file #(
  parameter int N     = 16,
  parameter int DISTW = 4,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DISTW-1:0]   wdata,
  output logic [N*DISTW-1:0] dist_flat
);
  logic [DISTW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < N)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign dist_flat[g*DISTW +: DISTW] = mem[g];
  end
endmodule

// File: rtl/bopg_min_pick.sv
module bopg_min_pick #(
  parameter int N     = 16,
  parameter int DISTW = 4,
  parameter int IDXW  = 4
) (
  input  logic [N*DISTW-1:0] dist_flat,
  input  logic [N-1:0]       skip,
  output logic [IDXW-1:0]    pick_idx,
  output logic               pick_ok
);
  logic [DISTW-1:0] best;

  always_comb begin
    best     = '1;
    pick_idx = '0;
    pick_ok  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!skip[i] && (!pick_ok || (dist_flat[i*DISTW +: DISTW] < best))) begin
        pick_ok  = 1'b1;
        best     = dist_flat[i*DISTW +: DISTW];
        pick_idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/bopg_nearest_live.sv
module bopg_nearest_live #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int IDXW = 4,
  localparam int N   = ROWS * COLS
) (
  input  logic [N-1:0]    off_mask,
  input  logic [IDXW-1:0] self_idx,
  output logic [IDXW-1:0] tgt_idx,
  output logic            has_live
);
  int sr, sc, dr, dc, d, best;
  logic [IDXW-1:0] best_idx;

  always_comb begin
    sr       = int'(self_idx) / COLS;
    sc       = int'(self_idx) % COLS;
    best     = 0;
    best_idx = self_idx;
    has_live = 1'b0;
    dr = 0; dc = 0; d = 0;
    for (int j = 0; j < N; j++) begin
      dr = (j / COLS) - sr;
      dc = (j % COLS) - sc;
      d  = ((dr < 0) ? -dr : dr) + ((dc < 0) ? -dc : dc);
      if (!off_mask[j] && (!has_live || d < best)) begin
        has_live = 1'b1;
        best     = d;
        best_idx = IDXW'(j);
      end
    end
    tgt_idx = (off_mask[self_idx] && has_live) ? best_idx : self_idx;
  end
endmodule

// File: rtl/bank_off_pattern_gen.sv
module bank_off_pattern_gen
  import bopg_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DISTW = 4,
  localparam int N    = ROWS * COLS,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int CNTW = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        pattern,
  input  logic [CNTW-1:0]   off_count,
  input  logic              dist_we,
  input  logic [IDXW-1:0]   dist_addr,
  input  logic [DISTW-1:0]  dist_wdata,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [N-1:0]      off_mask,
  output logic [N*IDXW-1:0] target_flat
);
  st_e             state_q;
  logic [1:0]      pat_q;
  logic [CNTW-1:0] remain_q, req_q;
  logic [IDXW-1:0] idx_q;
  logic [N-1:0]    mask_q;
  logic [IDXW-1:0] tgt_q [N];
  logic            ovf_q, ovf_pend_q;

  logic [N*DISTW-1:0] dist_flat;
  logic [IDXW-1:0]    pick_idx, near_idx;
  logic               pick_ok, has_live;
  logic               take;
  logic [CNTW-1:0]    remain_nx;

  bopg_dist_file #(.N(N), .DISTW(DISTW), .AW(IDXW)) u_dist (
    .clk(clk), .rst(rst), .we(dist_we), .waddr(dist_addr),
    .wdata(dist_wdata), .dist_flat(dist_flat));

  bopg_min_pick #(.N(N), .DISTW(DISTW), .IDXW(IDXW)) u_pick (
    .dist_flat(dist_flat), .skip(mask_q), .pick_idx(pick_idx), .pick_ok(pick_ok));

  bopg_nearest_live #(.ROWS(ROWS), .COLS(COLS), .IDXW(IDXW)) u_near (
    .off_mask(mask_q), .self_idx(idx_q), .tgt_idx(near_idx), .has_live(has_live));

  always_comb begin
    if (pat_q == PAT_NEAR) take = (remain_q != '0) && pick_ok;
    else take = (remain_q != '0) && walk_eligible(pat_q, int'(idx_q), COLS);
    remain_nx = take ? remain_q - CNTW'(1) : remain_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pat_q      <= '0;
      remain_q   <= '0;
      req_q      <= '0;
      idx_q      <= '0;
      mask_q     <= '0;
      ovf_q      <= 1'b0;
      ovf_pend_q <= 1'b0;
      for (int i = 0; i < N; i++) tgt_q[i] <= IDXW'(i);
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start) begin
          state_q    <= ST_SEL;
          pat_q      <= pattern;
          req_q      <= off_count;
          idx_q      <= '0;
          mask_q     <= '0;
          ovf_q      <= 1'b0;
          if (pattern == PAT_NEAR && int'(off_count) > N) begin
            remain_q   <= CNTW'(N);
            ovf_pend_q <= 1'b1;
          end else begin
            remain_q   <= off_count;
            ovf_pend_q <= 1'b0;
          end
        end
        ST_SEL: begin
          if (pat_q == PAT_NEAR) begin
            if (take) mask_q[pick_idx] <= 1'b1;
            remain_q <= remain_nx;
            if (remain_nx == '0) begin
              state_q <= ST_TGT;
              idx_q   <= '0;
            end
          end else begin
            if (take) mask_q[idx_q] <= 1'b1;
            remain_q <= remain_nx;
            if (int'(idx_q) == N - 1) begin
              state_q    <= ST_TGT;
              idx_q      <= '0;
              ovf_pend_q <= ovf_pend_q | (remain_nx != '0);
            end else begin
              idx_q <= idx_q + IDXW'(1);
            end
          end
        end
        ST_TGT: begin
          tgt_q[idx_q] <= near_idx;
          if (int'(idx_q) == N - 1) begin
            state_q <= ST_DONE;
            ovf_q   <= ovf_pend_q;
          end else begin
            idx_q <= idx_q + IDXW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == ST_SEL) || (state_q == ST_TGT);
  assign done     = (state_q == ST_DONE);
  assign overflow = ovf_q;
  assign off_mask = mask_q;
  for (genvar g = 0; g < N; g++) begin : g_tgt
    assign target_flat[g*IDXW +: IDXW] = tgt_q[g];
  end

  // Assertions
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_hold_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(off_mask) && $stable(overflow) && $stable(target_flat)));
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_count_match_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow) |-> ($countones(off_mask) == int'(req_q)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    overflow |-> done);
  assert_none_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (done && pat_q == PAT_NONE) |-> (off_mask == '0));
  assert_target_live_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TGT && mask_q[idx_q] && has_live) |-> !mask_q[near_idx]);
  assert_pick_free_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEL && pat_q == PAT_NEAR && take) |-> !mask_q[pick_idx]);
endmodule

// File: tb/tb_bank_off_pattern_gen.sv
module tb_bank_off_pattern_gen;
  localparam int ROWS = 4, COLS = 4, DISTW = 4;
  localparam int N = ROWS * COLS, IDXW = 4, CNTW = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dist_we = 1'b0;
  logic [1:0] pattern = '0;
  logic [CNTW-1:0] off_count = '0;
  logic [IDXW-1:0] dist_addr = '0;
  logic [DISTW-1:0] dist_wdata = '0;
  logic busy, done, overflow;
  logic [N-1:0] off_mask;
  logic [N*IDXW-1:0] target_flat;

  int errors = 0, checks = 0;
  int dist_m [N];

  always #2 clk = ~clk;

  bank_off_pattern_gen #(.ROWS(ROWS), .COLS(COLS), .DISTW(DISTW)) dut (
    .clk(clk), .rst(rst), .start(start), .pattern(pattern), .off_count(off_count),
    .dist_we(dist_we), .dist_addr(dist_addr), .dist_wdata(dist_wdata),
    .busy(busy), .done(done), .overflow(overflow), .off_mask(off_mask),
    .target_flat(target_flat));

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic allowed(input int pat, input int i);
    int r = i / COLS, c = i % COLS;
    if (pat == 0) return (r % 2) == 1;
    if (pat == 1) return ((r + c) % 2) == 1;
    return pat == 2;
  endfunction

  function automatic logic [N-1:0] exp_mask(input int pat, input int cnt);
    logic [N-1:0] m = '0;
    int left = cnt;
    if (pat == 2) begin
      while (left > 0 && m != '1) begin
        int bi = -1;
        for (int i = 0; i < N; i++)
          if (!m[i] && (bi < 0 || dist_m[i] < dist_m[bi])) bi = i;
        m[bi] = 1'b1;
        left--;
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (left > 0 && allowed(pat, i)) begin m[i] = 1'b1; left--; end
    end
    return m;
  endfunction

  function automatic int exp_tgt(input logic [N-1:0] m, input int i);
    int bj = -1, bd = 0;
    if (!m[i]) return i;
    for (int j = 0; j < N; j++) begin
      int d = ((j/COLS > i/COLS) ? j/COLS - i/COLS : i/COLS - j/COLS) +
              ((j%COLS > i%COLS) ? j%COLS - i%COLS : i%COLS - j%COLS);
      if (!m[j] && (bj < 0 || d < bd)) begin bj = j; bd = d; end
    end
    return (bj < 0) ? i : bj;
  endfunction

  task automatic run(input int pat, input int cnt, input string req);
    logic [N-1:0] m;
    int lim, cap;
    @(negedge clk);
    pattern = 2'(pat); off_count = CNTW'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R8 busy after start"}, 64'(busy), 64'd1);
    chk({req, " R8 done cleared"}, 64'(done), 64'd0);
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    m = exp_mask(pat, cnt);
    lim = 0;
    for (int i = 0; i < N; i++) lim += allowed(pat, i) ? 1 : 0;
    cap = (cnt < lim) ? cnt : lim;
    chk({req, " mask"}, 64'(off_mask), 64'(m));
    chk({req, " R5 count"}, 64'($countones(off_mask)), 64'(cap));
    chk({req, " R6 overflow"}, 64'(overflow), 64'(cnt > lim));
    for (int i = 0; i < N; i++)
      chk({req, " R7 target"}, 64'(target_flat[i*IDXW +: IDXW]), 64'(exp_tgt(m, i)));
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 mask", 64'(off_mask), 64'd0);
  endtask

  task automatic t_stripes();
    run(0, 3, "R2 stripes partial");
    chk("R2 banks 4..6", 64'(off_mask), 64'h0070);
    run(0, 8, "R2 stripes exact");
    run(0, 10, "R2 R6 stripes over");
  endtask

  task automatic t_check();
    run(1, 5, "R3 checker");
    chk("R3 banks 1,3,4,6,9", 64'(off_mask), 64'h025A);
  endtask

  task automatic t_near();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      dist_we = 1'b1; dist_addr = IDXW'(i);
      dist_m[i] = (i * 7) % 5;
      dist_wdata = DISTW'(dist_m[i]);
    end
    @(negedge clk);
    dist_we = 1'b0;
    run(2, 6, "R4 proximity");
    run(2, 20, "R4 R6 R7 proximity all");
  endtask

  task automatic t_none();
    run(3, 2, "R9 none");
    chk("R9 mask empty", 64'(off_mask), 64'd0);
    run(3, 0, "R9 none zero");
  endtask

  task automatic t_ignore();
    logic [N-1:0] held;
    @(negedge clk);
    pattern = 2'd1; off_count = CNTW'(4); start = 1'b1;
    @(negedge clk);
    pattern = 2'd0; off_count = CNTW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk("R8 mid-run start ignored", 64'(off_mask), 64'(exp_mask(1, 4)));
    held = off_mask;
    repeat (5) @(negedge clk);
    chk("R8 mask held", 64'(off_mask), 64'(held));
    chk("R8 done held", 64'(done), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stripes();
    t_check();
    t_near();
    t_none();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule